// File: doc/BRIEF.md
# Programmable Modulus Clock Divider

This block derives a microcontroller clock from the master clock by dividing it by an integer between 2 and 32. Software selects the ratio by writing a 5-bit code together with a one-cycle write strobe. The output holds a duty cycle of 50% for every ratio. Even ratios get this from whole master cycles. Odd ratios get it by stretching the high phase by half a master cycle, using a flop clocked on the falling master edge.

A written code is held as pending and takes effect only when the current output period ends. The output therefore never shows a shortened or lengthened pulse. Reset selects the slowest ratio, 32, so a 38.88 MHz master gives 1.215 MHz.

Top module: `mcu_clk_div`

## Requirements
- R1: While rst_n is low, clk_out is low. Reset selects ratio 32 for both the active and the pending setting.
- R2: On the first rising mclk edge after rst_n goes high, clk_out goes high and the first output period begins.
- R3: For an even ratio N, each output period lasts N mclk cycles, and clk_out is high for the first N/2 of them.
- R4: For an odd ratio N, each output period lasts N mclk cycles, and clk_out is high for the first N mclk half-periods. It falls on a falling mclk edge, so the high time is N/2 cycles.
- R5: The code on div_val is decoded when div_wr is high at a rising edge. Codes 2 to 31 select that ratio, code 0 selects ratio 32, and code 1 is raised to the minimum ratio 2.
- R6: A written ratio first applies to the period that begins after the current period ends. The current period completes at its old ratio.
- R7: A write registered on the same rising edge that starts a new period does not apply to that period. It applies from the period after it.
- R8: When several writes occur within one period, only the last one applies at the next period boundary.
- R9: clk_out has no glitch when the ratio changes: every high and low phase belongs to a complete period of one ratio.

Assumption, not a tested requirement: the block has no dedicated input for the duty-cycle window. The 40–60% duty limit is met because R3 and R4 together give 50% for every ratio from 2 to 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Write strobe for the ratio code, one mclk cycle wide |
| div_val | input | 5 | Ratio code (0 means 32, 1 is raised to 2) |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that div_val is stable whenever div_wr is high at a rising edge. They also assume that both inputs change only away from mclk edges. Reset may be asserted at any time.

The bench respects these assumptions. It changes div_wr and div_val shortly after a falling edge and drops the strobe one cycle later. It asserts reset in the middle of a cycle. Writes aimed at a period boundary are timed from the bench's own model of where the current period stands.

// File: rtl/mcu_clk_div.sv
module mcu_clk_div #(
  parameter int CODE_W    = 5,
  parameter int MIN_RATIO = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic [CODE_W-1:0] div_val,
  output logic              clk_out
);
  localparam int RW = CODE_W + 1;
  localparam logic [RW-1:0] MAXR = RW'(1 << CODE_W);
  localparam logic [RW-1:0] MINR = RW'(MIN_RATIO);

  logic [RW-1:0] wr_ratio, pend, ratio, cnt;
  logic [RW-1:0] ratio_nx, cnt_nx;
  logic          wrap, q_p, q_n, q_p_nx;

  always_comb begin
    if (div_val == '0)                wr_ratio = MAXR;
    else if ({1'b0, div_val} < MINR)  wr_ratio = MINR;
    else                              wr_ratio = {1'b0, div_val};
  end

  assign wrap     = (cnt == ratio - 1'b1);
  assign ratio_nx = wrap ? pend : ratio;
  assign cnt_nx   = wrap ? '0 : cnt + 1'b1;
  assign q_p_nx   = (cnt_nx < (ratio_nx >> 1));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= MAXR;
      ratio <= MAXR;
      cnt   <= MAXR - 1'b1;
      q_p   <= 1'b0;
    end else begin
      if (div_wr) pend <= wr_ratio;
      ratio <= ratio_nx;
      cnt   <= cnt_nx;
      q_p   <= q_p_nx;
    end
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b0;
    else        q_n <= q_p & ratio[0];
  end

  assign clk_out = q_p | q_n;
endmodule

module mcu_clk_div_chk #(
  parameter int RW = 6
) (
  input logic          mclk,
  input logic          rst_n,
  input logic          clk_out,
  input logic          q_p,
  input logic          q_n,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] ratio
);
  logic          booted;
  logic [RW-1:0] hi_cnt;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      booted <= 1'b0;
      hi_cnt <= '0;
    end else begin
      booted <= 1'b1;
      if (cnt == ratio - 1'b1) hi_cnt <= '0;
      else                     hi_cnt <= hi_cnt + RW'(q_p);
    end
  end

  // R1
  always @(negedge mclk) begin
    if (!rst_n) reset_low_chk: assert (!clk_out);
  end

  // R2
  first_high_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !booted |=> clk_out);

  // R3
  high_time_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (booted && cnt == ratio - 1'b1) |-> (hi_cnt + RW'(q_p) == (ratio >> 1)));

  // R4
  odd_ext_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    q_n |-> ratio[0]);

  // R5
  ratio_range_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (ratio >= RW'(2)) && (ratio <= RW'(1 << (RW - 1))));

  // R6
  ratio_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> (cnt == '0));
endmodule

bind mcu_clk_div mcu_clk_div_chk #(.RW(RW)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .clk_out(clk_out),
  .q_p(q_p), .q_n(q_n), .cnt(cnt), .ratio(ratio)
);

// File: tb/mcu_clk_div_test.sv
`timescale 1ns/1ps
module mcu_clk_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic [4:0] div_val = '0;
  logic       clk_out;

  mcu_clk_div uut (.mclk(clk), .rst_n(rst_n), .div_wr(div_wr),
                   .div_val(div_val), .clk_out(clk_out));

  always #10 clk = ~clk;

  integer n_cmp = 0, n_bad = 0;
  integer run = 0, mr = 32, mp = 32, k = 0;
  string  phase = "R1";
  bit     done = 1'b0;

  function automatic integer clamp(input logic [4:0] v);
    if (v == 0) return 32;
    if (v == 1) return 2;
    return int'(v);
  endfunction

  task automatic compare(input logic exp);
    n_cmp++;
    if (clk_out !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t clk_out=%b expected=%b ratio=%0d slot=%0d",
               phase, $time, clk_out, exp, mr, k);
    end
  endtask

  // Reference model: a period of ratio N is 2N half-slots, high for the first N
  always @(posedge clk) begin
    if (!rst_n) begin
      run = 0; mp = 32; mr = 32; k = 0;
    end else begin
      if (run == 0) begin
        run = 1; mr = mp; k = 0;
      end else begin
        k++;
        if (k == mr) begin k = 0; mr = mp; end
      end
      if (div_wr) mp = clamp(div_val);
    end
    #5 compare(rst_n && run != 0 && (2*k < mr));
    #10 compare(rst_n && run != 0 && (2*k + 1 < mr));
  end

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic write_code(input logic [4:0] v);
    @(negedge clk); #2; div_wr = 1'b1; div_val = v;
    @(negedge clk); #2; div_wr = 1'b0;
  endtask

  task automatic write_at_wrap(input logic [4:0] v);
    @(negedge clk);
    while (k != mr - 1) @(negedge clk);
    #2; div_wr = 1'b1; div_val = v;
    @(negedge clk); #2; div_wr = 1'b0;
  endtask

  task automatic periods(input integer n);
    repeat (n * mr + 2) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    phase = "R1 reset low";
    repeat (5) @(posedge clk);
    #3 rst_n = 1'b1;
    phase = "R2 first period";
    repeat (33) @(posedge clk);
    phase = "R3 default even 32";
    periods(2);
    phase = "R5 code 2 / R3";
    write_code(5'd2); periods(3);
    phase = "R5 code 3 / R4";
    write_code(5'd3); periods(3);
    phase = "R3 ratio 4";
    write_code(5'd4); periods(3);
    phase = "R4 ratio 5";
    write_code(5'd5); periods(3);
    phase = "R6 change mid-period 7 then 31";
    write_code(5'd7); periods(2);
    repeat (3) @(posedge clk);
    write_code(5'd31); periods(2);
    phase = "R5 code 0 means 32";
    write_code(5'd0); periods(2);
    phase = "R5 code 1 clamps to 2";
    write_code(5'd1); periods(4);
    phase = "R7 write on boundary";
    write_code(5'd9); periods(2);
    write_at_wrap(5'd6); periods(3);
    phase = "R8 last write wins";
    write_code(5'd3);
    write_code(5'd11); periods(3);
    phase = "R9 odd to even to odd";
    write_code(5'd16); periods(1);
    write_code(5'd13); periods(2);
    phase = "R1 async reset mid-run";
    @(negedge clk); #4 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    phase = "R2 restart at 32";
    periods(2);
    finish_up();
  end
endmodule